// File: doc/BRIEF.md
# Interrupt Pending and Mask Unit

This block holds an eight-bit vector of pending interrupt sources for a processor core and decides, every cycle, whether the core should take an interrupt. Software and hardware sources set or clear individual bits through post and clear requests that carry a source index. A clear-all request wipes the whole vector at once. An on-chip timer is also built in. It has a free-running count register and a compare register, and when the two are equal it sets one pending bit. A three-bit routing field chooses which bit that is.

The take-interrupt request is gated by the core's status fields: a global enable, an error-level flag, an exception-level flag and an eight-bit mask. Mask bit n qualifies pending bit n, with no shifting. A separate any-pending flag reports a non-empty vector no matter how the gating is set. Every output is registered. A request presented before a clock edge shows up on the outputs just after that edge.

Top module: `irq_pend_unit`

## Requirements
- R1: A post with index i in 0..7 sets pending bit i, and a clear with index i clears it, one clock edge later. If a post and a clear name the same bit in one cycle, the bit ends up set.
- R2: A clear-all zeroes the pending vector at the next edge. A post in the same cycle survives it, so only the newly posted bit remains.
- R3: A post or clear index of 8..15 leaves the pending vector unchanged. It also drives `idx_err` high for exactly one cycle after the edge on which it was presented.
- R4: `irq_req` is high only if `glb_en`=1, `err_lvl`=0, `exc_lvl`=0 and (`irq_mask` & `pend`) is non-zero. Any one failing condition drives it low after the next edge.
- R5: Mask bit n combines only with pending bit n. A mask that covers none of the set pending bits yields no request.
- R6: When compare equals count and count is non-zero, the pending bit numbered by `tmr_route` is set at the following edge.
- R7: A count of zero never produces a timer match, even when compare is also zero.
- R8: `any_pend` is high whenever the pending vector is non-zero, independent of the enable, level and mask inputs.
- R9: A timer-set pending bit stays set after the count moves past compare. It clears on the edge after a compare write.
- R10: The count increments by one per clock while `cnt_run`=1 and wraps from all ones to zero. A `cnt_wr` loads `cnt_wdata` and takes priority over the increment.
- R11: A synchronous active-high reset clears the pending vector, `irq_req`, `any_pend`, `idx_err`, the count and the compare value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| post_vld | input | 1 | Post request strobe |
| post_idx | input | 4 | Index of the bit to post (8..15 illegal) |
| clr_vld | input | 1 | Clear request strobe |
| clr_idx | input | 4 | Index of the bit to clear (8..15 illegal) |
| clr_all | input | 1 | Clear the whole pending vector |
| glb_en | input | 1 | Global interrupt enable |
| err_lvl | input | 1 | Error level active; blocks requests |
| exc_lvl | input | 1 | Exception level active; blocks requests |
| irq_mask | input | 8 | Per-source mask |
| cnt_run | input | 1 | Count increment enable |
| cnt_wr | input | 1 | Load strobe for the count |
| cnt_wdata | input | 32 | Count load value |
| cmp_wr | input | 1 | Compare write strobe; also clears the routed timer bit |
| cmp_wdata | input | 32 | Compare write value |
| tmr_route | input | 3 | Pending bit that the timer match drives |
| pend | output | 8 | Pending vector |
| irq_req | output | 1 | Take-interrupt request |
| any_pend | output | 1 | Pending vector is non-zero |
| idx_err | output | 1 | One-cycle flag for an illegal index |

## Verification
A wrong pending bit shows on `pend` and `any_pend` one edge after the request that caused it. It remains visible there until a later request corrects it, so sampling after every step catches it at once. Mistakes in the gating, such as an ignored level flag or a shifted mask, show on `irq_req` after the next edge while `pend` still looks correct. Timer faults are hidden inside the count. They surface only as a routed pending bit that rises one edge late or early, never rises, or rises when the count passes zero. The bench therefore steps the count across the match point and across the wrap one edge at a time and samples the vector at each step.

// File: rtl/irq_pkg.sv
package irq_pkg;
  localparam int IRQ_NUM_DEF = 8;
  localparam int IRQ_CNT_W_DEF = 32;

  function automatic bit idx_legal(input int unsigned idx, input int unsigned num);
    return idx < num;
  endfunction
endpackage

// File: rtl/irq_timer.sv
module irq_timer #(
  parameter int CNT_W = irq_pkg::IRQ_CNT_W_DEF
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cnt_run,
  input  logic             cnt_wr,
  input  logic [CNT_W-1:0] cnt_wdata,
  input  logic             cmp_wr,
  input  logic [CNT_W-1:0] cmp_wdata,
  output logic             hit
);
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cmp_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
      cmp_q <= '0;
    end else begin
      if (cnt_wr)       cnt_q <= cnt_wdata;
      else if (cnt_run) cnt_q <= cnt_q + CNT_W'(1);
      if (cmp_wr)       cmp_q <= cmp_wdata;
    end
  end

  assign hit = (cnt_q == cmp_q) && (cnt_q != '0);
endmodule

// File: rtl/irq_pend_reg.sv
module irq_pend_reg #(
  parameter int NUM_IRQ = irq_pkg::IRQ_NUM_DEF,
  localparam int IDX_W = $clog2(NUM_IRQ) + 1,
  localparam int RT_W  = $clog2(NUM_IRQ)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               post_vld,
  input  logic [IDX_W-1:0]   post_idx,
  input  logic               clr_vld,
  input  logic [IDX_W-1:0]   clr_idx,
  input  logic               clr_all,
  input  logic               tmr_hit,
  input  logic               tmr_clr,
  input  logic [RT_W-1:0]    tmr_route,
  output logic [NUM_IRQ-1:0] pend_q,
  output logic [NUM_IRQ-1:0] pend_nxt,
  output logic               idx_err
);
  logic bad_post, bad_clr;

  assign bad_post = post_vld && !irq_pkg::idx_legal(32'(post_idx), NUM_IRQ);
  assign bad_clr  = clr_vld  && !irq_pkg::idx_legal(32'(clr_idx), NUM_IRQ);

  for (genvar g = 0; g < NUM_IRQ; g++) begin : g_bit
    logic set_b, clr_b;
    assign set_b = (post_vld && post_idx == IDX_W'(g)) ||
                   (tmr_hit && tmr_route == RT_W'(g));
    assign clr_b = clr_all || (clr_vld && clr_idx == IDX_W'(g)) ||
                   (tmr_clr && tmr_route == RT_W'(g));
    assign pend_nxt[g] = set_b || (pend_q[g] && !clr_b);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q  <= '0;
      idx_err <= 1'b0;
    end else begin
      pend_q  <= pend_nxt;
      idx_err <= bad_post || bad_clr;
    end
  end
endmodule

// File: rtl/irq_gate.sv
module irq_gate #(
  parameter int NUM_IRQ = irq_pkg::IRQ_NUM_DEF
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_IRQ-1:0] pend_nxt,
  input  logic [NUM_IRQ-1:0] irq_mask,
  input  logic               glb_en,
  input  logic               err_lvl,
  input  logic               exc_lvl,
  output logic               irq_req,
  output logic               any_pend
);
  logic allow;
  assign allow = glb_en && !err_lvl && !exc_lvl;

  always_ff @(posedge clk) begin
    if (rst) begin
      irq_req  <= 1'b0;
      any_pend <= 1'b0;
    end else begin
      irq_req  <= allow && |(irq_mask & pend_nxt);
      any_pend <= |pend_nxt;
    end
  end
endmodule

// File: rtl/irq_pend_unit.sv
module irq_pend_unit #(
  parameter int NUM_IRQ = irq_pkg::IRQ_NUM_DEF,
  parameter int CNT_W   = irq_pkg::IRQ_CNT_W_DEF,
  localparam int IDX_W  = $clog2(NUM_IRQ) + 1,
  localparam int RT_W   = $clog2(NUM_IRQ)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               post_vld,
  input  logic [IDX_W-1:0]   post_idx,
  input  logic               clr_vld,
  input  logic [IDX_W-1:0]   clr_idx,
  input  logic               clr_all,
  input  logic               glb_en,
  input  logic               err_lvl,
  input  logic               exc_lvl,
  input  logic [NUM_IRQ-1:0] irq_mask,
  input  logic               cnt_run,
  input  logic               cnt_wr,
  input  logic [CNT_W-1:0]   cnt_wdata,
  input  logic               cmp_wr,
  input  logic [CNT_W-1:0]   cmp_wdata,
  input  logic [RT_W-1:0]    tmr_route,
  output logic [NUM_IRQ-1:0] pend,
  output logic               irq_req,
  output logic               any_pend,
  output logic               idx_err
);
  logic               tmr_hit;
  logic [NUM_IRQ-1:0] pend_nxt;

  irq_timer #(.CNT_W(CNT_W)) u_timer (
    .clk(clk), .rst(rst), .cnt_run(cnt_run), .cnt_wr(cnt_wr),
    .cnt_wdata(cnt_wdata), .cmp_wr(cmp_wr), .cmp_wdata(cmp_wdata),
    .hit(tmr_hit)
  );

  irq_pend_reg #(.NUM_IRQ(NUM_IRQ)) u_pend (
    .clk(clk), .rst(rst), .post_vld(post_vld), .post_idx(post_idx),
    .clr_vld(clr_vld), .clr_idx(clr_idx), .clr_all(clr_all),
    .tmr_hit(tmr_hit), .tmr_clr(cmp_wr), .tmr_route(tmr_route),
    .pend_q(pend), .pend_nxt(pend_nxt), .idx_err(idx_err)
  );

  irq_gate #(.NUM_IRQ(NUM_IRQ)) u_gate (
    .clk(clk), .rst(rst), .pend_nxt(pend_nxt), .irq_mask(irq_mask),
    .glb_en(glb_en), .err_lvl(err_lvl), .exc_lvl(exc_lvl),
    .irq_req(irq_req), .any_pend(any_pend)
  );
endmodule

// File: rtl/irq_pend_unit_chk.sv
module irq_pend_unit_chk #(
  parameter int NUM_IRQ = 8,
  localparam int IDX_W  = $clog2(NUM_IRQ) + 1,
  localparam int RT_W   = $clog2(NUM_IRQ)
) (
  input logic               clk,
  input logic               rst,
  input logic               post_vld,
  input logic [IDX_W-1:0]   post_idx,
  input logic               clr_vld,
  input logic [IDX_W-1:0]   clr_idx,
  input logic               clr_all,
  input logic               glb_en,
  input logic               err_lvl,
  input logic               exc_lvl,
  input logic               cmp_wr,
  input logic               tmr_hit,
  input logic [NUM_IRQ-1:0] pend,
  input logic               irq_req,
  input logic               any_pend,
  input logic               idx_err
);
  assert_post_sets_R1: assert property (@(posedge clk) disable iff (rst)
    (post_vld && 32'(post_idx) < NUM_IRQ) |=> pend[$past(post_idx[RT_W-1:0])]);

  assert_clear_all_R2: assert property (@(posedge clk) disable iff (rst)
    (clr_all && !post_vld && !tmr_hit) |=> (pend == '0));

  assert_bad_post_flag_R3: assert property (@(posedge clk) disable iff (rst)
    (post_vld && 32'(post_idx) >= NUM_IRQ) |=> idx_err);

  assert_bad_clr_flag_R3: assert property (@(posedge clk) disable iff (rst)
    (clr_vld && 32'(clr_idx) >= NUM_IRQ) |=> idx_err);

  assert_gate_block_R4: assert property (@(posedge clk) disable iff (rst)
    (!glb_en || err_lvl || exc_lvl) |=> !irq_req);

  assert_req_has_pend_R8: assert property (@(posedge clk) disable iff (rst)
    irq_req |-> any_pend);

  assert_hold_R9: assert property (@(posedge clk) disable iff (rst)
    (!post_vld && !clr_vld && !clr_all && !cmp_wr && !tmr_hit) |=> $stable(pend));
endmodule

bind irq_pend_unit irq_pend_unit_chk #(.NUM_IRQ(NUM_IRQ)) u_chk (
  .clk(clk), .rst(rst), .post_vld(post_vld), .post_idx(post_idx),
  .clr_vld(clr_vld), .clr_idx(clr_idx), .clr_all(clr_all),
  .glb_en(glb_en), .err_lvl(err_lvl), .exc_lvl(exc_lvl),
  .cmp_wr(cmp_wr), .tmr_hit(tmr_hit), .pend(pend),
  .irq_req(irq_req), .any_pend(any_pend), .idx_err(idx_err)
);

// File: tb/irq_pend_unit_test.sv
`timescale 1ns/1ps
module irq_pend_unit_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        post_vld = 1'b0, clr_vld = 1'b0, clr_all = 1'b0;
  logic [3:0]  post_idx = '0, clr_idx = '0;
  logic        glb_en = 1'b0, err_lvl = 1'b0, exc_lvl = 1'b0;
  logic [7:0]  irq_mask = '0;
  logic        cnt_run = 1'b0, cnt_wr = 1'b0, cmp_wr = 1'b0;
  logic [31:0] cnt_wdata = '0, cmp_wdata = '0;
  logic [2:0]  tmr_route = '0;
  logic [7:0]  pend;
  logic        irq_req, any_pend, idx_err;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  irq_pend_unit uut (
    .clk(clk), .rst(rst), .post_vld(post_vld), .post_idx(post_idx),
    .clr_vld(clr_vld), .clr_idx(clr_idx), .clr_all(clr_all),
    .glb_en(glb_en), .err_lvl(err_lvl), .exc_lvl(exc_lvl), .irq_mask(irq_mask),
    .cnt_run(cnt_run), .cnt_wr(cnt_wr), .cnt_wdata(cnt_wdata),
    .cmp_wr(cmp_wr), .cmp_wdata(cmp_wdata), .tmr_route(tmr_route),
    .pend(pend), .irq_req(irq_req), .any_pend(any_pend), .idx_err(idx_err)
  );

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic post(input logic [3:0] i);
    post_vld = 1'b1; post_idx = i; step(); post_vld = 1'b0;
  endtask

  task automatic clr(input logic [3:0] i);
    clr_vld = 1'b1; clr_idx = i; step(); clr_vld = 1'b0;
  endtask

  task automatic wipe();
    clr_all = 1'b1; step(); clr_all = 1'b0;
  endtask

  task automatic t_reset();
    check("R11 pend", 32'(pend), 0);
    check("R11 irq_req", 32'(irq_req), 0);
    check("R11 any_pend", 32'(any_pend), 0);
    check("R11 idx_err", 32'(idx_err), 0);
  endtask

  task automatic t_post_clear();
    post(4'd3); check("R1 post 3", 32'(pend), 32'h08);
    post(4'd5); check("R1 post 5", 32'(pend), 32'h28);
    clr(4'd3);  check("R1 clear 3", 32'(pend), 32'h20);
    post_vld = 1'b1; post_idx = 4'd1; clr_vld = 1'b1; clr_idx = 4'd1;
    step(); post_vld = 1'b0; clr_vld = 1'b0;
    check("R1 post beats clear", 32'(pend), 32'h22);
    clr(4'd5); clr(4'd1);
    check("R1 cleared", 32'(pend), 0);
  endtask

  task automatic t_clear_all();
    post(4'd0); post(4'd2); post(4'd7);
    check("R2 setup", 32'(pend), 32'h85);
    clr_all = 1'b1; post_vld = 1'b1; post_idx = 4'd4;
    step(); clr_all = 1'b0; post_vld = 1'b0;
    check("R2 clear-all keeps new post", 32'(pend), 32'h10);
    wipe();
    check("R2 clear-all", 32'(pend), 0);
    check("R8 empty", 32'(any_pend), 0);
  endtask

  task automatic t_illegal();
    post(4'd9);
    check("R3 bad post ignored", 32'(pend), 0);
    check("R3 flag", 32'(idx_err), 1);
    step();
    check("R3 flag one cycle", 32'(idx_err), 0);
    post(4'd0);
    clr(4'd12);
    check("R3 bad clear ignored", 32'(pend), 32'h01);
    check("R3 clear flag", 32'(idx_err), 1);
    step();
    check("R3 clear flag drops", 32'(idx_err), 0);
  endtask

  task automatic t_gate();
    irq_mask = 8'h01; glb_en = 1'b1; step();
    check("R4 enabled", 32'(irq_req), 1);
    err_lvl = 1'b1; step();
    check("R4 error level", 32'(irq_req), 0);
    check("R8 any under error level", 32'(any_pend), 1);
    err_lvl = 1'b0; exc_lvl = 1'b1; step();
    check("R4 exception level", 32'(irq_req), 0);
    exc_lvl = 1'b0; glb_en = 1'b0; step();
    check("R4 disabled", 32'(irq_req), 0);
    check("R8 any while disabled", 32'(any_pend), 1);
    glb_en = 1'b1; step();
    check("R4 re-enabled", 32'(irq_req), 1);
  endtask

  task automatic t_mask();
    irq_mask = 8'hFE; step();
    check("R5 other bits masked", 32'(irq_req), 0);
    check("R8 any while masked", 32'(any_pend), 1);
    wipe(); post(4'd7);
    irq_mask = 8'h40; step();
    check("R5 neighbour mask", 32'(irq_req), 0);
    irq_mask = 8'h80; step();
    check("R5 aligned mask", 32'(irq_req), 1);
    wipe();
    check("R4 no pending", 32'(irq_req), 0);
  endtask

  task automatic t_timer();
    tmr_route = 3'd5;
    cnt_wr = 1'b1; cnt_wdata = 32'd100; cmp_wr = 1'b1; cmp_wdata = 32'd100;
    step(); cnt_wr = 1'b0; cmp_wr = 1'b0;
    check("R6 before match edge", 32'(pend), 0);
    step();
    check("R6 routed bit set", 32'(pend), 32'h20);
    cnt_run = 1'b1;
    for (int k = 0; k < 5; k++) step();
    cnt_run = 1'b0;
    check("R9 held past compare", 32'(pend), 32'h20);
    cmp_wr = 1'b1; cmp_wdata = 32'd5000; step(); cmp_wr = 1'b0;
    check("R9 compare write clears", 32'(pend), 0);
  endtask

  task automatic t_wrap();
    tmr_route = 3'd2;
    cnt_wr = 1'b1; cnt_wdata = 32'hFFFF_FFFE; cmp_wr = 1'b1; cmp_wdata = 32'd1;
    step(); cnt_wr = 1'b0; cmp_wr = 1'b0;
    cnt_run = 1'b1;
    step(); step(); step();
    check("R10 no early match", 32'(pend), 0);
    step();
    check("R10 wrapped to 1 matches", 32'(pend), 32'h04);
    cnt_run = 1'b0;
    cmp_wr = 1'b1; cmp_wdata = 32'd0; step(); cmp_wr = 1'b0;
    check("R9 cleared by compare", 32'(pend), 0);
    cnt_wr = 1'b1; cnt_wdata = 32'hFFFF_FFFE; step(); cnt_wr = 1'b0;
    cnt_run = 1'b1;
    for (int k = 0; k < 4; k++) step();
    cnt_run = 1'b0;
    check("R7 zero count no match", 32'(pend), 0);
    cnt_wr = 1'b1; cnt_wdata = 32'd0; step(); cnt_wr = 1'b0;
    step(); step();
    check("R7 parked at zero", 32'(pend), 0);
  endtask

  initial begin
    step(); step(); step();
    rst = 1'b0;
    t_reset();
    t_post_clear();
    t_clear_all();
    t_illegal();
    t_gate();
    t_mask();
    t_timer();
    t_wrap();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    for (int c = 0; c < 20000; c++) begin
      @(posedge clk);
      if (done) break;
    end
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule